// File: doc/BRIEF.md
# JTAG Debug Command Controller

This block sits behind a JTAG TAP state machine, clocked by TCK, and turns debug scans into actions on a processor core. A 10-bit command word picks a target debug register, the transfer direction and the go/exit controls. A 32-bit capture/shift register carries the data. Read data is sampled from the core when the TAP passes through Capture-DR and leaves on TDO least significant bit first. Write data is handed to the core as a one-cycle strobe after Update-DR.

A GO command asks the core to run the instruction held in its scan-chain register. It is honoured only when the select is the CPU scan-chain code or the no-register code, and only while the core reports debug mode. It launches at Update-DR. EX picks between a single step, after which the core returns to debug mode, and a full resume, during which asynchronous interrupts stay blocked until the first instruction starts. Codes that no register decodes behave as a 1-bit bypass. A status register reports debug mode, the interrupt block and a sticky "step blocked" error.

The TAP state input `cmd_scan_i` routes a DR scan to the command word instead of the data path. The testbench models the TAP state machine and the core.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: A command scan (cmd_scan_i=1) captures the current command word at Capture-DR, shifts it out on tdo_o with TDI entering at bit 9 (bit 0 leaves first), and loads the shifted word at Update-DR. Layout: bit 0 = rw, bit 1 = go, bit 2 = ex, bits 9:3 = 7-bit register select.
- R2: On rst_ni low, and in every cycle that tap_tlr_i is high, the command word is 10'h011 (rw=1, go=0, ex=0, select 7'h02). reg_sel_o shows the select.
- R3: For selects below GEN_NUM (16), the CPU scan code 7'h10 and the PC-FIFO code 7'h12, Capture-DR samples rd_data_i. The 32 bits then leave on tdo_o LSB first, one per Shift-DR cycle, sampled before each shift edge.
- R4: With rw=0 and a select below 16 or 7'h10, Update-DR raises wr_o for exactly one cycle on the following edge. wr_data_o then holds the shift register contents. TDI enters at bit 31, so a shorter shift of n bits writes the captured value shifted right by n with the new bits at the top.
- R5: Any other select (including 7'h7F) is a 1-bit bypass. The first bit out is 0 and every later bit is TDI delayed by one shift. No write strobe is issued.
- R6: go_o pulses for one cycle after Update-DR of a data scan only when go=1, the select is 7'h10 or 7'h7F and dbg_mode_i=1. Otherwise GO is ignored.
- R7: exit_o pulses together with go_o when ex=1. It stays low for a step (ex=0).
- R8: irq_block_o rises with a go+exit launch and clears on instr_start_i.
- R9: pcf_adv_o pulses once after Capture-DR with select 7'h12 only when rw=1.
- R10: step_blocked_i sets err_o, which holds until a Capture-DR of the status code 7'h11 clears it. Status reads return bit 0 = dbg_mode_i, bit 1 = err, bit 2 = irq_block, with the other bits zero. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | TCK |
| rst_ni | input | 1 | Active-low async reset (TRST or power-on) |
| tap_tlr_i | input | 1 | TAP in Test-Logic-Reset |
| tap_capture_i | input | 1 | TAP in Capture-DR |
| tap_shift_i | input | 1 | TAP in Shift-DR |
| tap_update_i | input | 1 | TAP in Update-DR |
| cmd_scan_i | input | 1 | DR scan targets the command word |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| reg_sel_o | output | 7 | Selected debug register |
| rd_data_i | input | 32 | Read value of the selected register |
| wr_o | output | 1 | One-cycle write strobe |
| wr_data_o | output | 32 | Write value |
| pcf_adv_o | output | 1 | PC history FIFO pointer advance |
| go_o | output | 1 | Execute-instruction pulse |
| exit_o | output | 1 | Resume-normal-execution pulse |
| dbg_mode_i | input | 1 | Core is in debug mode |
| step_blocked_i | input | 1 | Core could not run the requested instruction |
| instr_start_i | input | 1 | First instruction after resume has begun |
| irq_block_o | output | 1 | Asynchronous interrupts blocked |
| err_o | output | 1 | Sticky step-blocked error |

## Verification
The hardest condition to reach is the sticky error reported through the status register. A read has to sample the error in the same capture that clears it, and a second read must then show it gone. The bench pulses step_blocked_i and then runs two full status scans back to back, checking bit 1 of each serial result. Partial shifts and bypass alignment are reached by scans of chosen lengths and by comparing every TDO bit against the TDI stream one shift earlier.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
  localparam int CMD_W = 10;
  localparam int RS_W  = 7;

  typedef struct packed {
    logic [RS_W-1:0] rs;
    logic            ex;
    logic            go;
    logic            rw;
  } cmd_t;

  localparam cmd_t CMD_RST = '{rs: 7'h02, ex: 1'b0, go: 1'b0, rw: 1'b1};

  typedef enum logic [2:0] {
    CLS_GEN, CLS_CPU, CLS_STAT, CLS_PCF, CLS_NOREG, CLS_BYP
  } cls_e;
endpackage

// File: rtl/dbg_cmd_reg.sv
module dbg_cmd_reg
  import dbg_cmd_pkg::*;
#(
  parameter logic [RS_W-1:0] CPU_SEL   = 7'h10,
  parameter logic [RS_W-1:0] NOREG_SEL = 7'h7F,
  parameter logic [RS_W-1:0] STAT_SEL  = 7'h11,
  parameter logic [RS_W-1:0] PCF_SEL   = 7'h12,
  parameter int              GEN_NUM   = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tlr_i,
  input  logic sel_i,
  input  logic capture_i,
  input  logic shift_i,
  input  logic update_i,
  input  logic tdi_i,
  output logic tdo_o,
  output cmd_t cmd_o,
  output cls_e cls_o
);
  logic [CMD_W-1:0] sr_q;
  cmd_t             cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cmd_q <= CMD_RST;
    end else if (tlr_i) begin
      cmd_q <= CMD_RST;
    end else if (sel_i) begin
      if (capture_i)     sr_q  <= cmd_q;
      else if (shift_i)  sr_q  <= {tdi_i, sr_q[CMD_W-1:1]};
      else if (update_i) cmd_q <= sr_q;
    end
  end

  always_comb begin
    if (cmd_q.rs == CPU_SEL)                     cls_o = CLS_CPU;
    else if (cmd_q.rs == STAT_SEL)               cls_o = CLS_STAT;
    else if (cmd_q.rs == PCF_SEL)                cls_o = CLS_PCF;
    else if (cmd_q.rs == NOREG_SEL)              cls_o = CLS_NOREG;
    else if (32'(cmd_q.rs) < GEN_NUM)            cls_o = CLS_GEN;
    else                                         cls_o = CLS_BYP;
  end

  assign tdo_o = sr_q[0];
  assign cmd_o = cmd_q;

  assert_tlr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlr_i |=> (cmd_q == CMD_RST));
endmodule

// File: rtl/dbg_data_path.sv
module dbg_data_path
  import dbg_cmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  input  cls_e              cls_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              tdo_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              pcf_adv_o,
  output logic              stat_rd_o
);
  logic [DATA_W-1:0] sr_q, wdata_q;
  logic              byp_q, wr_q, pcf_q;
  logic              is_byp, can_wr;

  assign is_byp = (cls_i == CLS_BYP) || (cls_i == CLS_NOREG);
  assign can_wr = (cls_i == CLS_GEN) || (cls_i == CLS_CPU);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      wdata_q <= '0;
      byp_q   <= 1'b0;
      wr_q    <= 1'b0;
      pcf_q   <= 1'b0;
    end else begin
      wr_q  <= 1'b0;
      pcf_q <= 1'b0;
      if (active_i && capture_i) begin
        if (is_byp) byp_q <= 1'b0;
        else        sr_q  <= (cls_i == CLS_STAT) ? status_i : rd_data_i;
        pcf_q <= (cls_i == CLS_PCF) && rw_i;
      end else if (active_i && shift_i) begin
        if (is_byp) byp_q <= tdi_i;
        else        sr_q  <= {tdi_i, sr_q[DATA_W-1:1]};
      end else if (active_i && update_i && can_wr && !rw_i) begin
        wr_q    <= 1'b1;
        wdata_q <= sr_q;
      end
    end
  end

  assign tdo_o     = is_byp ? byp_q : sr_q[0];
  assign wr_o      = wr_q;
  assign wr_data_o = wdata_q;
  assign pcf_adv_o = pcf_q;
  assign stat_rd_o = active_i && capture_i && (cls_i == CLS_STAT);

  assert_wr_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |=> !wr_q);
  assert_pcf_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcf_q |=> !pcf_q);
endmodule

// File: rtl/dbg_go_ctrl.sv
module dbg_go_ctrl
  import dbg_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic go_i,
  input  logic ex_i,
  input  cls_e cls_i,
  input  logic dbg_mode_i,
  input  logic step_blocked_i,
  input  logic instr_start_i,
  input  logic stat_rd_i,
  output logic go_o,
  output logic exit_o,
  output logic irq_block_o,
  output logic err_o
);
  logic launch, go_q, exit_q, irq_q, err_q;

  assign launch = fire_i && go_i && dbg_mode_i &&
                  ((cls_i == CLS_CPU) || (cls_i == CLS_NOREG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q   <= 1'b0;
      exit_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      go_q   <= launch;
      exit_q <= launch && ex_i;
      if (launch && ex_i)     irq_q <= 1'b1;
      else if (instr_start_i) irq_q <= 1'b0;
      // set wins over a same-cycle status read
      if (step_blocked_i)     err_q <= 1'b1;
      else if (stat_rd_i)     err_q <= 1'b0;
    end
  end

  assign go_o        = go_q;
  assign exit_o      = exit_q;
  assign irq_block_o = irq_q;
  assign err_o       = err_q;

  assert_go_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_q |=> !go_q);
  assert_exit_needs_go_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_q |-> go_q);
  assert_irq_from_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> exit_q);
  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_blocked_i |=> err_q);
endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
  import dbg_cmd_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter logic [RS_W-1:0] CPU_SEL   = 7'h10,
  parameter logic [RS_W-1:0] NOREG_SEL = 7'h7F,
  parameter logic [RS_W-1:0] STAT_SEL  = 7'h11,
  parameter logic [RS_W-1:0] PCF_SEL   = 7'h12,
  parameter int              GEN_NUM   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tap_tlr_i,
  input  logic              tap_capture_i,
  input  logic              tap_shift_i,
  input  logic              tap_update_i,
  input  logic              cmd_scan_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic [RS_W-1:0]   reg_sel_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              pcf_adv_o,
  output logic              go_o,
  output logic              exit_o,
  input  logic              dbg_mode_i,
  input  logic              step_blocked_i,
  input  logic              instr_start_i,
  output logic              irq_block_o,
  output logic              err_o
);
  cmd_t              cmd;
  cls_e              cls;
  logic              cmd_tdo, dat_tdo, stat_rd, data_act;
  logic [DATA_W-1:0] status;

  assign data_act = !cmd_scan_i;
  assign status   = {{(DATA_W-3){1'b0}}, irq_block_o, err_o, dbg_mode_i};

  dbg_cmd_reg #(
    .CPU_SEL(CPU_SEL), .NOREG_SEL(NOREG_SEL), .STAT_SEL(STAT_SEL),
    .PCF_SEL(PCF_SEL), .GEN_NUM(GEN_NUM)
  ) u_cmd (
    .clk_i, .rst_ni, .tlr_i(tap_tlr_i), .sel_i(cmd_scan_i),
    .capture_i(tap_capture_i), .shift_i(tap_shift_i), .update_i(tap_update_i),
    .tdi_i, .tdo_o(cmd_tdo), .cmd_o(cmd), .cls_o(cls)
  );

  dbg_data_path #(.DATA_W(DATA_W)) u_dat (
    .clk_i, .rst_ni, .active_i(data_act),
    .capture_i(tap_capture_i), .shift_i(tap_shift_i), .update_i(tap_update_i),
    .tdi_i, .cls_i(cls), .rw_i(cmd.rw), .rd_data_i, .status_i(status),
    .tdo_o(dat_tdo), .wr_o, .wr_data_o, .pcf_adv_o, .stat_rd_o(stat_rd)
  );

  dbg_go_ctrl u_go (
    .clk_i, .rst_ni, .fire_i(data_act && tap_update_i),
    .go_i(cmd.go), .ex_i(cmd.ex), .cls_i(cls), .dbg_mode_i,
    .step_blocked_i, .instr_start_i, .stat_rd_i(stat_rd),
    .go_o, .exit_o, .irq_block_o, .err_o
  );

  assign tdo_o     = cmd_scan_i ? cmd_tdo : dat_tdo;
  assign reg_sel_o = cmd.rs;
endmodule

// File: tb/sim_dbg_cmd_ctrl.sv
module sim_dbg_cmd_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tlr = 0, cap = 0, sh = 0, upd = 0, csel = 0, tdi = 0;
  logic tdo, wr, pcf, go, ex_o, irqb, err;
  logic dbgm = 1'b1, sblk = 1'b0, istart = 1'b0;
  logic [6:0]  sel;
  logic [31:0] rd = '0, wd;
  int n_chk = 0, n_fail = 0;
  int go_cnt = 0, ex_cnt = 0, wr_cnt = 0, pcf_cnt = 0;
  logic [31:0] last_wd = '0;

  always #4 clk = ~clk;

  dbg_cmd_ctrl u0 (
    .clk_i(clk), .rst_ni, .tap_tlr_i(tlr), .tap_capture_i(cap),
    .tap_shift_i(sh), .tap_update_i(upd), .cmd_scan_i(csel), .tdi_i(tdi),
    .tdo_o(tdo), .reg_sel_o(sel), .rd_data_i(rd), .wr_o(wr), .wr_data_o(wd),
    .pcf_adv_o(pcf), .go_o(go), .exit_o(ex_o), .dbg_mode_i(dbgm),
    .step_blocked_i(sblk), .instr_start_i(istart), .irq_block_o(irqb),
    .err_o(err)
  );

  always @(posedge clk) begin
    if (go)   go_cnt++;
    if (ex_o) ex_cnt++;
    if (pcf)  pcf_cnt++;
    if (wr) begin wr_cnt++; last_wd = wd; end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic scan_cmd(input logic [9:0] v, output logic [9:0] o);
    o = '0;
    csel = 1; cap = 1; cyc(); cap = 0; sh = 1;
    for (int i = 0; i < 10; i++) begin tdi = v[i]; #1 o[i] = tdo; cyc(); end
    sh = 0; upd = 1; cyc(); upd = 0; csel = 0; cyc();
  endtask

  task automatic scan_dat(input logic [31:0] w, input int n, output logic [31:0] o);
    o = '0;
    cap = 1; cyc(); cap = 0; sh = 1;
    for (int i = 0; i < n; i++) begin tdi = w[i]; #1 o[i] = tdo; cyc(); end
    sh = 0; upd = 1; cyc(); upd = 0; cyc(); cyc();
  endtask

  typedef struct packed {
    logic [9:0]  cmd;
    logic [31:0] rdv;
    logic [31:0] wdv;
    logic [31:0] tdov;
    logic        wr, go, ex;
  } vec_t;

  // cmd = {select, ex, go, rw}
  localparam vec_t VECS [7] = '{
    '{{7'h05, 3'b001}, 32'hA5A50F0F, 32'h00000000, 32'hA5A50F0F, 1'b0, 1'b0, 1'b0},
    '{{7'h05, 3'b000}, 32'h0BADF00D, 32'h12345678, 32'h0BADF00D, 1'b1, 1'b0, 1'b0},
    '{{7'h10, 3'b011}, 32'hCAFE0001, 32'h00000000, 32'hCAFE0001, 1'b0, 1'b1, 1'b0},
    '{{7'h10, 3'b110}, 32'h00000010, 32'h87654321, 32'h00000010, 1'b1, 1'b1, 1'b1},
    '{{7'h7F, 3'b110}, 32'h00000000, 32'h3C3C5A5A, 32'h7878B4B4, 1'b0, 1'b1, 1'b1},
    '{{7'h03, 3'b011}, 32'h11112222, 32'h00000000, 32'h11112222, 1'b0, 1'b0, 1'b0},
    '{{7'h40, 3'b001}, 32'hFFFFFFFF, 32'h80000001, 32'h00000002, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [9:0]  oc;
    logic [31:0] od;
    int g0, e0, w0, p0;
    repeat (3) cyc();
    // R2 reset state
    chk(sel == 7'h02, "R2 reset select", 32'(sel), 32'h02);
    chk(!go && !ex_o && !wr && !irqb && !err, "R2 reset outputs",
        {27'b0, go, ex_o, wr, irqb, err}, 32'h0);
    rst_ni = 1; cyc();
    scan_cmd(10'h011, oc);
    chk(oc == 10'h011, "R1 R2 reset command word", 32'(oc), 32'h011);

    // table walk: R1 R3 R4 R5 R6 R7
    for (int i = 0; i < 7; i++) begin
      scan_cmd(VECS[i].cmd, oc);
      if (i > 0) chk(oc == VECS[i-1].cmd, "R1 command readback", 32'(oc), 32'(VECS[i-1].cmd));
      rd = VECS[i].rdv;
      g0 = go_cnt; e0 = ex_cnt; w0 = wr_cnt;
      scan_dat(VECS[i].wdv, 32, od);
      chk(od == VECS[i].tdov, "R3 R5 tdo stream", od, VECS[i].tdov);
      chk((wr_cnt - w0) == int'(VECS[i].wr), "R4 write strobe", 32'(wr_cnt - w0), 32'(VECS[i].wr));
      if (VECS[i].wr) chk(last_wd == VECS[i].wdv, "R4 write data", last_wd, VECS[i].wdv);
      chk((go_cnt - g0) == int'(VECS[i].go), "R6 go pulse", 32'(go_cnt - g0), 32'(VECS[i].go));
      chk((ex_cnt - e0) == int'(VECS[i].ex), "R7 exit pulse", 32'(ex_cnt - e0), 32'(VECS[i].ex));
      istart = 1; cyc(); istart = 0;
    end

    // R2 Test-Logic-Reset hold
    scan_cmd({7'h05, 3'b000}, oc);
    chk(sel == 7'h05, "R1 select loaded", 32'(sel), 32'h05);
    tlr = 1; cyc(); cyc(); tlr = 0;
    chk(sel == 7'h02, "R2 TLR restores select", 32'(sel), 32'h02);

    // R4 partial shift
    scan_cmd({7'h01, 3'b000}, oc);
    rd = 32'h0; w0 = wr_cnt;
    scan_dat(32'h000000AB, 8, od);
    chk(wr_cnt - w0 == 1, "R4 partial write strobe", 32'(wr_cnt - w0), 32'd1);
    chk(last_wd == 32'hAB000000, "R4 partial write data", last_wd, 32'hAB000000);

    // R9 PC FIFO advance only on rw=1
    scan_cmd({7'h12, 3'b001}, oc);
    p0 = pcf_cnt; scan_dat(32'h0, 32, od);
    chk(pcf_cnt - p0 == 1, "R9 advance on read", 32'(pcf_cnt - p0), 32'd1);
    scan_cmd({7'h12, 3'b000}, oc);
    p0 = pcf_cnt; scan_dat(32'h0, 32, od);
    chk(pcf_cnt - p0 == 0, "R9 no advance on write", 32'(pcf_cnt - p0), 32'd0);

    // R10 sticky error and status read clear
    sblk = 1; cyc(); sblk = 0; cyc();
    chk(err == 1'b1, "R10 err set", 32'(err), 32'd1);
    scan_cmd({7'h11, 3'b001}, oc);
    scan_dat(32'h0, 32, od);
    chk(od == 32'h3, "R10 status shows err", od, 32'h3);
    chk(err == 1'b0, "R10 err cleared", 32'(err), 32'd0);
    w0 = wr_cnt;
    scan_cmd({7'h11, 3'b000}, oc);
    scan_dat(32'hFFFFFFFF, 32, od);
    chk(od == 32'h1, "R10 second status read", od, 32'h1);
    chk(wr_cnt == w0, "R10 status write ignored", 32'(wr_cnt - w0), 32'd0);

    // R6 GO ignored outside debug mode
    dbgm = 0;
    scan_cmd({7'h10, 3'b011}, oc);
    g0 = go_cnt; scan_dat(32'h0, 32, od);
    chk(go_cnt == g0, "R6 go needs debug mode", 32'(go_cnt - g0), 32'd0);
    dbgm = 1;

    // R8 interrupt block lifetime
    scan_cmd({7'h7F, 3'b110}, oc);
    scan_dat(32'h0, 32, od);
    chk(irqb == 1'b1, "R8 irq blocked after exit", 32'(irqb), 32'd1);
    cyc(); cyc();
    chk(irqb == 1'b1, "R8 irq block holds", 32'(irqb), 32'd1);
    istart = 1; cyc(); istart = 0;
    chk(irqb == 1'b0, "R8 irq released", 32'(irqb), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule